// File: doc/BRIEF.md
# Jacobi Rotation Parameter Unit

This unit computes the parameters of one plane rotation for a one-sided Jacobi singular value decomposition. It takes the squared norms of two columns and their covariance. It returns the rotation tangent, the cosine and the sine, and the two norms as they stand after the rotation, with the covariance of the pair taken as zero. A small sequencer runs the whole computation on a deliberately small set of shared arithmetic: one multiplier, two adders, one radix-2 iterative divider and one radix-2 iterative square-root unit. Independent sub-steps overlap where the data allow. The norm update, for example, runs on the multiplier and adders while the square root for the cosine is in progress.

All values are 32-bit signed fixed point with 8 integer bits (sign included) and 24 fraction bits, so 1.0 is `0x01000000`. The ratio is rho = (n2 - n1) / (2c). The tangent is t = sign(rho) / (|rho| + sqrt(1 + rho^2)), and sign(0) counts as +1. Then cos = 1 / sqrt(1 + t^2) and sin = cos * t. The norms become n2 + t*c and n1 - t*c. A zero covariance skips all arithmetic. A second mode reuses the square-root unit to turn a diagonal entry into a singular value.

A request is taken only while the unit is idle. Requests made while it is busy are dropped. Every result is announced with a one-cycle `done` pulse, and the outputs stay unchanged until the next pulse.

Top module: `jacobi_rot_unit`

## Requirements
- R1: While `busy` is low, a high `start` on a clock edge captures `sv_mode`, `n1_in`, `n2_in` and `cov_in` and raises `busy` on that edge. `busy` stays high until the edge that raises `done`, and falls on that same edge.
- R2: For a rotation with nonzero covariance, `t_out` equals sign(rho)/(|rho|+sqrt(1+rho^2)) with rho=(n2-n1)/(2c), within 3e-5. rho = 0 gives t = +1.
- R3: For a rotation with nonzero covariance, `cos_out` = 1/sqrt(1+t^2) and `sin_out` = cos*t, each within 3e-5. `cos_out` is never negative.
- R4: For a rotation with nonzero covariance, `n2_out` = n2 + t*c and `n1_out` = n1 - t*c, within 3e-5.
- R5: A rotation with `cov_in` = 0 gives t = 0, cos = 1.0, sin = 0, `n1_out` = n1 and `n2_out` = n2 exactly. Its `done` appears 2 clock edges after the accepting edge, counting that edge as the first.
- R6: When |rho| >= 11.0, the tangent is sign(rho)/(2|rho|) and the square root of 1+rho^2 is not used. A ratio beyond the format's range saturates to the largest positive value, just below 128.0, before this step.
- R7: A rotation with nonzero covariance raises `done` exactly 3*(W+1+FRAC) + 2*RW/2 + 7 clock edges after the accepting edge, counting that edge as the first. This is 234 with the default parameters, where RW = 56.
- R8: With `sv_mode` = 1, `sv_out` = sqrt(`n1_in`) within 3e-5, and a negative input gives 0. `done` follows RW/2 + 2 = 30 edges after the accepting edge. The rotation outputs keep their values.
- R9: A `start` made while `busy` is high is ignored. The running request completes with its own results and latency, and `sv_out` is not touched.
- R10: `done` lasts exactly one cycle. Every result output holds its value in every cycle in which `done` is low.
- R11: After reset, `busy`, `done` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when not busy |
| sv_mode | input | 1 | 0: rotation request, 1: singular-value request |
| n1_in | input | W | Squared norm of the first column, or the diagonal entry in singular-value mode |
| n2_in | input | W | Squared norm of the second column |
| cov_in | input | W | Covariance of the two columns |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: results updated |
| t_out | output | W | Rotation tangent |
| cos_out | output | W | Rotation cosine |
| sin_out | output | W | Rotation sine |
| n1_out | output | W | Updated first norm |
| n2_out | output | W | Updated second norm |
| sv_out | output | W | Singular value |

## Verification
Every result is due at a fixed edge that can be counted in advance. A zero-covariance rotation completes on the 2nd edge, a full rotation on the 234th (three 57-step divisions and two 28-step square roots plus seven sequencing edges), and a singular value on the 30th. The bench drives each request half a cycle before the accepting edge and counts edges while sampling at falling edges. It checks that `done` first appears at exactly that count, then compares every output against real-number values computed from the formulas. A sweep over a grid of norm and covariance values covers both signs of rho, rho = 0, the large-ratio path and the saturated ratio. A request injected halfway through a rotation must change neither the count nor any result.

// File: rtl/jr_pkg.sv
package jr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SV,
        ST_PREP,
        ST_RHO,
        ST_R1,
        ST_T,
        ST_TC,
        ST_R2,
        ST_COS
    } jr_state_e;

endpackage

// File: rtl/jr_adder.sv
module jr_adder #(
    parameter int AW = 34
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          sub,
    output logic [AW-1:0] y
);
    // two's complement add or subtract; the caller sizes AW so no wrap occurs
    always_comb begin
        y = sub ? (a - b) : (a + b);
    end
endmodule

// File: rtl/jr_mult.sv
module jr_mult #(
    parameter int W    = 32,
    parameter int FRAC = 24
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam logic signed [2*W-1:0] HI = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [2*W-1:0] LO = {{(W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [2*W-1:0] full;
    logic signed [2*W-1:0] scaled;

    always_comb begin
        full   = a * b;
        scaled = full >>> FRAC;
        if (scaled > HI) begin
            p = HI[W-1:0];
        end else if (scaled < LO) begin
            p = LO[W-1:0];
        end else begin
            p = scaled[W-1:0];
        end
    end
endmodule

// File: rtl/jr_divider.sv
module jr_divider #(
    parameter int OPW  = 33,
    parameter int FRAC = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [OPW-1:0]      num,
    input  logic [OPW-1:0]      den,
    output logic [OPW+FRAC-1:0] quo,
    output logic                valid
);
    localparam int QW = OPW + FRAC;
    localparam int CW = $clog2(QW + 1);

    typedef struct packed {
        logic [QW-1:0]  dvd;
        logic [OPW-1:0] den;
        logic [OPW:0]   rem;
        logic [QW-1:0]  quo;
        logic [CW-1:0]  cnt;
        logic           valid;
    } div_regs_t;

    div_regs_t cur_q, nxt_d;
    logic [OPW:0] rem_sh;
    logic         ge;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        rem_sh      = {cur_q.rem[OPW-1:0], cur_q.dvd[QW-1]};
        ge          = (rem_sh >= {1'b0, cur_q.den});
        if (start) begin
            nxt_d.dvd = {num, {FRAC{1'b0}}};
            nxt_d.den = den;
            nxt_d.rem = '0;
            nxt_d.quo = '0;
            nxt_d.cnt = CW'(QW);
        end else if (cur_q.cnt != '0) begin
            nxt_d.rem   = ge ? (rem_sh - {1'b0, cur_q.den}) : rem_sh;
            nxt_d.quo   = {cur_q.quo[QW-2:0], ge};
            nxt_d.dvd   = {cur_q.dvd[QW-2:0], 1'b0};
            nxt_d.cnt   = cur_q.cnt - 1'b1;
            nxt_d.valid = (cur_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign quo   = cur_q.quo;
    assign valid = cur_q.valid;
endmodule

// File: rtl/jr_sqrt.sv
module jr_sqrt #(
    parameter int RW = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RW-1:0]     rad,
    output logic [RW/2-1:0]   root,
    output logic              valid
);
    localparam int HW = RW / 2;
    localparam int CW = $clog2(HW + 1);

    typedef struct packed {
        logic [RW-1:0]   rad;
        logic [HW+1:0]   rem;
        logic [HW-1:0]   root;
        logic [CW-1:0]   cnt;
        logic            valid;
    } sq_regs_t;

    sq_regs_t cur_q, nxt_d;
    logic [HW+2:0] rem_sh;
    logic [HW+2:0] trial;
    logic          ge;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        rem_sh      = {cur_q.rem[HW:0], cur_q.rad[RW-1:RW-2]};
        trial       = {1'b0, cur_q.root, 2'b01};
        ge          = (rem_sh >= trial);
        if (start) begin
            nxt_d.rad  = rad;
            nxt_d.rem  = '0;
            nxt_d.root = '0;
            nxt_d.cnt  = CW'(HW);
        end else if (cur_q.cnt != '0) begin
            nxt_d.rem   = ge ? (rem_sh[HW+1:0] - trial[HW+1:0]) : rem_sh[HW+1:0];
            nxt_d.root  = {cur_q.root[HW-2:0], ge};
            nxt_d.rad   = {cur_q.rad[RW-3:0], 2'b00};
            nxt_d.cnt   = cur_q.cnt - 1'b1;
            nxt_d.valid = (cur_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign root  = cur_q.root;
    assign valid = cur_q.valid;
endmodule

// File: rtl/jacobi_rot_unit.sv
module jacobi_rot_unit
    import jr_pkg::*;
#(
    parameter int W       = 32,
    parameter int FRAC    = 24,
    parameter int BIG_INT = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sv_mode,
    input  logic [W-1:0] n1_in,
    input  logic [W-1:0] n2_in,
    input  logic [W-1:0] cov_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] t_out,
    output logic [W-1:0] cos_out,
    output logic [W-1:0] sin_out,
    output logic [W-1:0] n1_out,
    output logic [W-1:0] n2_out,
    output logic [W-1:0] sv_out
);
    localparam int OPW     = W + 1;
    localparam int QW      = OPW + FRAC;
    localparam int RAD_RAW = W - 1 + FRAC;
    localparam int RW      = RAD_RAW + (RAD_RAW % 2);
    localparam int HW      = RW / 2;
    localparam int AW      = W + 2;

    localparam logic [W-1:0] ONE    = {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] BIG_TH = W'(BIG_INT) << FRAC;

    typedef struct packed {
        jr_state_e    st;
        logic         busy;
        logic         done;
        logic [W-1:0] n1;
        logic [W-1:0] n2;
        logic [W-1:0] c;
        logic [W-1:0] rho;
        logic         rho_neg;
        logic         big;
        logic [W-1:0] t_w;
        logic [W-1:0] n1_w;
        logic [W-1:0] n2_w;
        logic [W-1:0] t_o;
        logic [W-1:0] cos_o;
        logic [W-1:0] sin_o;
        logic [W-1:0] n1_o;
        logic [W-1:0] n2_o;
        logic [W-1:0] sv_o;
    } regs_t;

    regs_t cur_q, nxt_d;

    // shared arithmetic
    logic [W-1:0]   mul_a, mul_b, mul_p;
    logic [AW-1:0]  aa_a, aa_b, aa_y, ab_a, ab_b, ab_y;
    logic           aa_sub, ab_sub;
    logic           div_start, div_valid;
    logic [OPW-1:0] div_num, div_den;
    logic [QW-1:0]  div_quo;
    logic           sq_start, sq_valid;
    logic [RW-1:0]  sq_rad;
    logic [HW-1:0]  sq_root;

    function automatic logic [AW-1:0] ext2(input logic [W-1:0] v);
        return {{2{v[W-1]}}, v};
    endfunction

    function automatic logic [W-1:0] sat2(input logic [AW-1:0] v);
        if (!v[AW-1] && (v[W:W-1] != 2'b00)) begin
            return MAXPOS;
        end else if (v[AW-1] && (v[W:W-1] != 2'b11)) begin
            return MINNEG;
        end else begin
            return v[W-1:0];
        end
    endfunction

    function automatic logic [W-1:0] satq(input logic [QW-1:0] q);
        if (|q[QW-1:W-1]) begin
            return MAXPOS;
        end else begin
            return q[W-1:0];
        end
    endfunction

    function automatic logic [OPW-1:0] mag(input logic [AW-1:0] v);
        logic [AW-1:0] a;
        a = v[AW-1] ? (~v + 1'b1) : v;
        return a[OPW-1:0];
    endfunction

    function automatic logic [RW-1:0] rad_of(input logic [W-1:0] v);
        return RW'({v[W-2:0], {FRAC{1'b0}}});
    endfunction

    jr_mult #(.W(W), .FRAC(FRAC)) u_mul (
        .a(mul_a), .b(mul_b), .p(mul_p)
    );

    jr_adder #(.AW(AW)) u_add_a (
        .a(aa_a), .b(aa_b), .sub(aa_sub), .y(aa_y)
    );

    jr_adder #(.AW(AW)) u_add_b (
        .a(ab_a), .b(ab_b), .sub(ab_sub), .y(ab_y)
    );

    jr_divider #(.OPW(OPW), .FRAC(FRAC)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den), .quo(div_quo), .valid(div_valid)
    );

    jr_sqrt #(.RW(RW)) u_sqrt (
        .clk(clk), .rst_n(rst_n), .start(sq_start),
        .rad(sq_rad), .root(sq_root), .valid(sq_valid)
    );

    always_comb begin
        logic [W-1:0] rho_m;
        logic [W-1:0] tmag;
        logic [W-1:0] t_new;
        logic [W-1:0] cos_new;
        logic [W-1:0] root_w;

        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        mul_a      = '0;
        mul_b      = '0;
        aa_a       = '0;
        aa_b       = '0;
        aa_sub     = 1'b0;
        ab_a       = '0;
        ab_b       = '0;
        ab_sub     = 1'b0;
        div_start  = 1'b0;
        div_num    = '0;
        div_den    = '0;
        sq_start   = 1'b0;
        sq_rad     = '0;
        rho_m      = satq(div_quo);
        tmag       = satq(div_quo);
        t_new      = cur_q.rho_neg ? (~tmag + 1'b1) : tmag;
        cos_new    = satq(div_quo);
        root_w     = W'(sq_root);

        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.busy = 1'b1;
                    nxt_d.n1   = n1_in;
                    nxt_d.n2   = n2_in;
                    nxt_d.c    = cov_in;
                    if (sv_mode) begin
                        sq_start = 1'b1;
                        sq_rad   = n1_in[W-1] ? '0 : rad_of(n1_in);
                        nxt_d.st = ST_SV;
                    end else begin
                        nxt_d.st = ST_PREP;
                    end
                end
            end

            ST_SV: begin
                if (sq_valid) begin
                    nxt_d.sv_o = root_w;
                    nxt_d.done = 1'b1;
                    nxt_d.busy = 1'b0;
                    nxt_d.st   = ST_IDLE;
                end
            end

            ST_PREP: begin
                // both adders: difference of norms and doubled covariance
                aa_a   = ext2(cur_q.n2);
                aa_b   = ext2(cur_q.n1);
                aa_sub = 1'b1;
                ab_a   = ext2(cur_q.c);
                ab_b   = ext2(cur_q.c);
                if (cur_q.c == '0) begin
                    nxt_d.t_o   = '0;
                    nxt_d.cos_o = ONE;
                    nxt_d.sin_o = '0;
                    nxt_d.n1_o  = cur_q.n1;
                    nxt_d.n2_o  = cur_q.n2;
                    nxt_d.done  = 1'b1;
                    nxt_d.busy  = 1'b0;
                    nxt_d.st    = ST_IDLE;
                end else begin
                    div_start     = 1'b1;
                    div_num       = mag(aa_y);
                    div_den       = mag(ab_y);
                    nxt_d.rho_neg = (aa_y != '0) && (aa_y[AW-1] ^ ab_y[AW-1]);
                    nxt_d.st      = ST_RHO;
                end
            end

            ST_RHO: begin
                if (div_valid) begin
                    nxt_d.rho = rho_m;
                    nxt_d.big = (rho_m >= BIG_TH);
                    mul_a     = rho_m;
                    mul_b     = rho_m;
                    aa_a      = ext2(ONE);
                    aa_b      = ext2(mul_p);
                    sq_start  = 1'b1;
                    sq_rad    = (rho_m >= BIG_TH) ? rad_of(ONE) : rad_of(sat2(aa_y));
                    nxt_d.st  = ST_R1;
                end
            end

            ST_R1: begin
                if (sq_valid) begin
                    aa_a      = ext2(cur_q.rho);
                    aa_b      = cur_q.big ? ext2(cur_q.rho) : ext2(root_w);
                    div_start = 1'b1;
                    div_num   = OPW'(ONE);
                    div_den   = aa_y[OPW-1:0];
                    nxt_d.st  = ST_T;
                end
            end

            ST_T: begin
                if (div_valid) begin
                    nxt_d.t_w = t_new;
                    mul_a     = t_new;
                    mul_b     = t_new;
                    aa_a      = ext2(ONE);
                    aa_b      = ext2(mul_p);
                    sq_start  = 1'b1;
                    sq_rad    = rad_of(sat2(aa_y));
                    nxt_d.st  = ST_TC;
                end
            end

            ST_TC: begin
                // runs while the square root for the cosine is stepping
                mul_a      = cur_q.t_w;
                mul_b      = cur_q.c;
                aa_a       = ext2(cur_q.n2);
                aa_b       = ext2(mul_p);
                ab_a       = ext2(cur_q.n1);
                ab_b       = ext2(mul_p);
                ab_sub     = 1'b1;
                nxt_d.n2_w = sat2(aa_y);
                nxt_d.n1_w = sat2(ab_y);
                nxt_d.st   = ST_R2;
            end

            ST_R2: begin
                if (sq_valid) begin
                    div_start = 1'b1;
                    div_num   = OPW'(ONE);
                    div_den   = OPW'(sq_root);
                    nxt_d.st  = ST_COS;
                end
            end

            ST_COS: begin
                if (div_valid) begin
                    mul_a       = cos_new;
                    mul_b       = cur_q.t_w;
                    nxt_d.t_o   = cur_q.t_w;
                    nxt_d.cos_o = cos_new;
                    nxt_d.sin_o = mul_p;
                    nxt_d.n1_o  = cur_q.n1_w;
                    nxt_d.n2_o  = cur_q.n2_w;
                    nxt_d.done  = 1'b1;
                    nxt_d.busy  = 1'b0;
                    nxt_d.st    = ST_IDLE;
                end
            end

            default: begin
                nxt_d.st   = ST_IDLE;
                nxt_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy    = cur_q.busy;
    assign done    = cur_q.done;
    assign t_out   = cur_q.t_o;
    assign cos_out = cur_q.cos_o;
    assign sin_out = cur_q.sin_o;
    assign n1_out  = cur_q.n1_o;
    assign n2_out  = cur_q.n2_o;
    assign sv_out  = cur_q.sv_o;
endmodule

// File: rtl/jacobi_rot_unit_chk.sv
module jacobi_rot_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] t_out,
    input logic [W-1:0] cos_out,
    input logic [W-1:0] sin_out,
    input logic [W-1:0] n1_out,
    input logic [W-1:0] n2_out,
    input logic [W-1:0] sv_out
);
    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r1_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({t_out, cos_out, sin_out, n1_out, n2_out, sv_out}));

    a_r3_cos_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        !cos_out[W-1]);

    a_r8_sv_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        !sv_out[W-1]);
endmodule

bind jacobi_rot_unit jacobi_rot_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .t_out(t_out), .cos_out(cos_out), .sin_out(sin_out),
    .n1_out(n1_out), .n2_out(n2_out), .sv_out(sv_out)
);

// File: tb/tb_jacobi_rot_unit.sv
module tb_jacobi_rot_unit;
    localparam int  ROT_LAT = 3 * (32 + 1 + 24) + 2 * 28 + 7;
    localparam int  SV_LAT  = 28 + 2;
    localparam real SCALE   = 16777216.0;
    localparam real TOL     = 3.0e-5;
    localparam real MAXR    = 2147483647.0 / 16777216.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sv_mode = 1'b0;
    logic [31:0] n1_in = '0;
    logic [31:0] n2_in = '0;
    logic [31:0] cov_in = '0;
    logic        busy, done;
    logic [31:0] t_out, cos_out, sin_out, n1_out, n2_out, sv_out;

    int checks = 0;
    int errors = 0;

    jacobi_rot_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sv_mode(sv_mode),
        .n1_in(n1_in), .n2_in(n2_in), .cov_in(cov_in),
        .busy(busy), .done(done), .t_out(t_out), .cos_out(cos_out),
        .sin_out(sin_out), .n1_out(n1_out), .n2_out(n2_out), .sv_out(sv_out)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] fx(input real r);
        return 32'($rtoi(r * SCALE));
    endfunction

    function automatic real fr(input logic [31:0] x);
        return $itor($signed(x)) / SCALE;
    endfunction

    task automatic chk_real(input string rq, input string what, input real act, input real exp);
        real d;
        checks++;
        d = act - exp;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            errors++;
            $display("FAIL %s %s actual=%f expected=%f", rq, what, act, exp);
        end
    endtask

    task automatic chk_int(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // real-number model of R2, R3, R4, R5, R6
    task automatic model(input real n1, input real n2, input real c,
                         output real t, output real co, output real si,
                         output real m1, output real m2);
        real rho, a;
        if (c == 0.0) begin
            t = 0.0;
        end else begin
            rho = (n2 - n1) / (2.0 * c);
            a = (rho < 0.0) ? -rho : rho;
            if (a > MAXR) a = MAXR;
            if (a >= 11.0) t = 1.0 / (2.0 * a);
            else t = 1.0 / (a + $sqrt(1.0 + a * a));
            if (rho < 0.0) t = -t;
        end
        co = 1.0 / $sqrt(1.0 + t * t);
        si = co * t;
        m2 = n2 + t * c;
        m1 = n1 - t * c;
    endtask

    task automatic run_rot(input real n1, input real n2, input real c, input bit intrude);
        real et, ec, es, e1, e2;
        int lat;
        logic [31:0] sv_before;
        sv_before = sv_out;
        model(n1, n2, c, et, ec, es, e1, e2);
        @(negedge clk);
        n1_in = fx(n1); n2_in = fx(n2); cov_in = fx(c); sv_mode = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n1_in = fx(77.0); n2_in = fx(-5.0); cov_in = fx(0.5);
        lat = 1;
        chk_int("R1", "busy after accept", busy, 1);
        while (!done && lat < 2000) begin
            if (intrude && lat == 40) begin
                start = 1'b1; sv_mode = 1'b1; n1_in = fx(50.0);
            end else begin
                start = 1'b0; sv_mode = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start = 1'b0; sv_mode = 1'b0;
        if (c == 0.0) begin
            chk_int("R5", "zero-cov latency", lat, 2);
            chk_int("R5", "zero-cov t raw", t_out, 0);
            chk_int("R5", "zero-cov cos raw", cos_out, 32'h0100_0000);
            chk_int("R5", "zero-cov sin raw", sin_out, 0);
            chk_int("R5", "zero-cov n1 raw", n1_out, fx(n1));
            chk_int("R5", "zero-cov n2 raw", n2_out, fx(n2));
        end else begin
            chk_int("R7", "rotation latency", lat, ROT_LAT);
            chk_real("R2", "t", fr(t_out), et);
            chk_real("R3", "cos", fr(cos_out), ec);
            chk_real("R3", "sin", fr(sin_out), es);
            chk_real("R4", "n1'", fr(n1_out), e1);
            chk_real("R4", "n2'", fr(n2_out), e2);
        end
        chk_int("R1", "busy low at done", busy, 0);
        if (intrude) chk_int("R9", "sv_out untouched by ignored start", sv_out, sv_before);
        @(negedge clk);
        chk_int("R10", "done lasts one cycle", done, 0);
    endtask

    task automatic run_sv(input real d, input real expd);
        int lat;
        logic [31:0] t0, c0, s0, a0, b0;
        t0 = t_out; c0 = cos_out; s0 = sin_out; a0 = n1_out; b0 = n2_out;
        @(negedge clk);
        n1_in = fx(d); sv_mode = 1'b1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; sv_mode = 1'b0; n1_in = fx(9.0);
        lat = 1;
        while (!done && lat < 2000) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        chk_int("R8", "singular latency", lat, SV_LAT);
        chk_real("R8", "singular value", fr(sv_out), expd);
        chk_int("R8", "rotation outputs kept",
                longint'({t_out, cos_out, sin_out, a0 == n1_out, b0 == n2_out}),
                longint'({t0, c0, s0, 1'b1, 1'b1}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        real nv[5];
        real cv[6];
        nv = '{0.0, 0.5, 1.75, 3.0, 10.0};
        cv = '{-2.5, -0.75, -0.125, 0.375, 1.0, 4.0};

        repeat (3) @(negedge clk);
        // R11 reset state
        chk_int("R11", "busy at reset", busy, 0);
        chk_int("R11", "done at reset", done, 0);
        chk_int("R11", "outputs at reset",
                longint'(t_out | cos_out | sin_out | n1_out | n2_out | sv_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_int("R11", "idle after reset", busy, 0);

        // R2 R3 R4 R6 grid sweep
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                for (int k = 0; k < 6; k++) begin
                    run_rot(nv[i], nv[j], cv[k], 1'b0);
                end
            end
        end

        // R5 zero covariance
        run_rot(2.0, 5.0, 0.0, 1'b0);
        run_rot(7.25, 0.5, 0.0, 1'b0);

        // R2 rho = 0 gives positive tangent of 1
        run_rot(4.0, 4.0, -1.5, 1'b0);
        chk_real("R2", "rho zero t", fr(t_out), 1.0);

        // R6 saturated ratio
        run_rot(0.0, 1.0, 1.0 / SCALE, 1'b0);
        chk_real("R6", "saturated t", fr(t_out), 1.0 / (2.0 * MAXR));

        // R8 singular values
        run_sv(0.0, 0.0);
        run_sv(0.25, 0.5);
        run_sv(1.0, 1.0);
        run_sv(2.0, $sqrt(2.0));
        run_sv(100.0, 10.0);
        run_sv(127.5, $sqrt(127.5));
        run_sv(-3.0, 0.0);

        // R9 start while busy is ignored
        run_rot(1.0, 6.0, 0.75, 1'b1);
        run_rot(9.0, 2.0, -0.5, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule